// File: doc/BRIEF.md
# Multi-level round-robin bus arbiter

This block decides which of eight masters owns a shared pipelined bus in the next cycle. Each master presents a 3-bit request level. Level 0 means the master is not requesting. Levels 1 to 7 are strict priorities. The highest pending level always wins. Masters that tie at that level are served in rotation, and each level keeps its own rotation pointer, so fairness at one level is not disturbed by traffic at another.

A master that holds the grant can raise its hold bit to keep the bus for a locked sequence. While hold is active, nothing else can take the bus, not even a higher level, a stop or a low enable. A stop input blocks every new grant and is echoed as a system stop output. An enable input lets an outside controller gate the arbiter. The arbiter also reports its highest pending level, so that several copies can be combined by outside logic that chooses which copy to enable.

Top module: `prio_rr_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `gnt_o` is all zero and every level's rotation pointer starts at port 0. The first arbitration at any level therefore picks the lowest-numbered requester at that level.
- R2: Port m's level sits in bits [3m+2:3m] of `req_lvl_i`. A level of 0 is no request, and a port at level 0 is never granted.
- R3: `gnt_o` is registered and at most one bit is set. It shows, one clock after the inputs are sampled, a master whose level equals the highest pending level.
- R4: Within a level, after master m is granted at that level, the next grant at that level goes to the first master requesting at that level found by counting upward from m+1 and wrapping after port 7.
- R5: A level's pointer moves only when a grant is issued at that level. Traffic at other levels leaves it where it was.
- R6: If the currently granted master raises its bit of `hold_i`, the grant is unchanged in the next cycle whatever the requests, `stop_i` or `en_i` are. No pointer moves while the grant is held.
- R7: Hold bits of masters that are not granted have no effect on the grant.
- R8: While `stop_i` is high and no hold is active, the next-cycle grant is zero. `stop_o` equals `stop_i` in the same cycle.
- R9: While `en_i` is low and no hold is active, the next-cycle grant is zero and no pointer moves.
- R10: `top_lvl_o` is combinational and equals the highest level present on the ports, or 0 when nobody requests. It does not depend on hold, stop or enable.
- R11: Without hold, a granted master that drops its request loses the grant in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_lvl_i | input | 24 | Eight 3-bit request levels, port m at bits [3m+2:3m] |
| hold_i | input | 8 | Per-master hold; only the granted master's bit counts |
| en_i | input | 1 | Arbitration enable |
| stop_i | input | 1 | System stop request |
| gnt_o | output | 8 | One-hot registered grant |
| stop_o | output | 1 | System stop echo |
| top_lvl_o | output | 3 | Highest pending request level |

## Verification
On every cycle the assertions check the following properties:
- the grant is one-hot or empty;
- a held grant stays put;
- stop or a low enable empties the grant;
- a fresh grant lands on a master at the top level;
- an idle level's pointer does not move.

The exact rotation order within a level, the way each level's pointer is preserved across bursts at other levels, and the way hold interacts with stop and enable can only be seen from the bench's scenarios. In those scenarios a behavioural reference model is compared with the grant and level outputs on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  parameter int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/arb_lvl_max.sv
module arb_lvl_max
  import arb_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8
) (
  input  logic [NUM_PORTS*LVL_W-1:0] lvl_i,
  output lvl_t                       max_o
);
  always_comb begin
    max_o = '0;
    for (int m = 0; m < NUM_PORTS; m++) begin
      if (lvl_i[m*LVL_W +: LVL_W] > max_o) max_o = lvl_i[m*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/arb_rr_level.sv
module arb_rr_level #(
  parameter int unsigned NUM_PORTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic                 adv_i,
  output logic [NUM_PORTS-1:0] gnt_o
);
  localparam int unsigned IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick_idx;

  // first requester at or after ptr_q, wrapping
  always_comb begin
    logic found;
    found    = 1'b0;
    gnt_o    = '0;
    pick_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      int j;
      j = (int'(ptr_q) + i) % NUM_PORTS;
      if (!found && req_i[j]) begin
        found    = 1'b1;
        gnt_o[j] = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (pick_idx == IW'(NUM_PORTS - 1)) ? '0 : pick_idx + IW'(1);
  end

  a_r5_ptr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));

endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PORTS*LVL_W-1:0] req_lvl_i,
  input  logic [NUM_PORTS-1:0]       hold_i,
  input  logic                       en_i,
  input  logic                       stop_i,
  output logic [NUM_PORTS-1:0]       gnt_o,
  output logic                       stop_o,
  output lvl_t                       top_lvl_o
);
  localparam int unsigned NUM_LVL = (1 << LVL_W) - 1;

  logic [NUM_PORTS-1:0] lvl_req [1:NUM_LVL];
  logic [NUM_PORTS-1:0] lvl_gnt [1:NUM_LVL];
  logic [NUM_LVL:1]     lvl_adv;
  logic [NUM_PORTS-1:0] gnt_q, gnt_d, pick_gnt, top_mask;
  lvl_t                 top_lvl;
  logic                 lock, arb_go;

  arb_lvl_max #(.NUM_PORTS(NUM_PORTS)) u_max (
    .lvl_i (req_lvl_i),
    .max_o (top_lvl)
  );

  assign lock   = |(gnt_q & hold_i);
  assign arb_go = !lock && en_i && !stop_i;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    for (genvar m = 0; m < NUM_PORTS; m++) begin : g_port
      assign lvl_req[l][m] = (req_lvl_i[m*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign lvl_adv[l] = arb_go && (top_lvl == LVL_W'(l));

    arb_rr_level #(.NUM_PORTS(NUM_PORTS)) u_rr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (lvl_req[l]),
      .adv_i  (lvl_adv[l]),
      .gnt_o  (lvl_gnt[l])
    );
  end

  always_comb begin
    pick_gnt = '0;
    top_mask = '0;
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (top_lvl == LVL_W'(l)) begin
        pick_gnt = lvl_gnt[l];
        top_mask = lvl_req[l];
      end
    end
  end

  always_comb begin
    if (lock)        gnt_d = gnt_q;
    else if (arb_go) gnt_d = pick_gnt;
    else             gnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o     = gnt_q;
  assign stop_o    = stop_i;
  assign top_lvl_o = top_lvl;

  a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));

  a_r3_top_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_go && top_lvl != '0) |=> |(gnt_q & $past(top_mask)));

  a_r6_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> gnt_q == $past(gnt_q));

  a_r8_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock && stop_i) |=> gnt_q == '0);

  a_r9_en_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock && !en_i) |=> gnt_q == '0);

endmodule

// File: tb/prio_rr_arbiter_test.sv
`timescale 1ns/1ps
module prio_rr_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] req_lvl;
  logic [7:0]  hold;
  logic        en, stop;
  logic [7:0]  gnt;
  logic        stop_o;
  logic [2:0]  top_lvl;

  int nvec = 0;
  int nfail = 0;
  int ptr [1:7];
  int mg;

  always #2.5 clk = ~clk;

  prio_rr_arbiter uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_lvl_i (req_lvl),
    .hold_i    (hold),
    .en_i      (en),
    .stop_i    (stop),
    .gnt_o     (gnt),
    .stop_o    (stop_o),
    .top_lvl_o (top_lvl)
  );

  function automatic int lvl_of(int p);
    return int'(req_lvl[p*3 +: 3]);
  endfunction

  function automatic int model_top();
    int t = 0;
    for (int p = 0; p < 8; p++) if (lvl_of(p) > t) t = lvl_of(p);
    return t;
  endfunction

  function automatic logic [7:0] model_gnt();
    return (mg < 0) ? 8'h00 : 8'(1 << mg);
  endfunction

  task automatic set_lvl(int p, int v);
    req_lvl[p*3 +: 3] = 3'(v);
  endtask

  task automatic model_update();
    int t;
    if (mg >= 0 && hold[mg]) return;
    if (stop || !en) begin mg = -1; return; end
    t = model_top();
    mg = -1;
    if (t == 0) return;
    for (int i = 0; i < 8; i++) begin
      int j = (ptr[t] + i) % 8;
      if (lvl_of(j) == t) begin
        mg = j;
        ptr[t] = (j + 1) % 8;
        break;
      end
    end
  endtask

  // inputs are set at negedge; comb outputs checked, then one clock
  task automatic step(input string tag);
    #1;
    nvec++;
    if (top_lvl !== 3'(model_top())) begin
      nfail++;
      $display("FAIL R10 (%s): top_lvl_o=%0d expected %0d", tag, top_lvl, model_top());
    end
    nvec++;
    if (stop_o !== stop) begin
      nfail++;
      $display("FAIL R8 (%s): stop_o=%0b expected %0b", tag, stop_o, stop);
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    nvec++;
    if (gnt !== model_gnt()) begin
      nfail++;
      $display("FAIL %s: gnt_o=%02h expected %02h", tag, gnt, model_gnt());
    end
  endtask

  task automatic expect_gnt(input string tag, input int port);
    logic [7:0] e;
    e = (port < 0) ? 8'h00 : 8'(1 << port);
    nvec++;
    if (gnt !== e) begin
      nfail++;
      $display("FAIL %s: gnt_o=%02h expected %02h", tag, gnt, e);
    end
  endtask

  task automatic clear_all();
    req_lvl = '0; hold = '0; en = 1'b1; stop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    mg = -1;
    for (int l = 1; l <= 7; l++) ptr[l] = 0;
    rst_n = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    expect_gnt("R1", -1);
    rst_n = 1'b1;
    step("R1");
    expect_gnt("R1", -1);

    // R2: level 0 on every port, nothing granted
    step("R2");
    expect_gnt("R2", -1);

    // R4/R1: all eight at level 3 rotate from port 0
    for (int p = 0; p < 8; p++) set_lvl(p, 3);
    step("R1");
    expect_gnt("R1", 0);
    for (int k = 1; k < 10; k++) begin
      step("R4");
      expect_gnt("R4", k % 8);
    end

    // R3: level 7 beats level 5; R2: level 0 ports ignored
    clear_all();
    set_lvl(2, 5); set_lvl(6, 5); set_lvl(1, 7);
    step("R3");
    expect_gnt("R3", 1);
    set_lvl(1, 0);
    step("R11");
    expect_gnt("R11", 2);
    step("R4");
    expect_gnt("R4", 6);
    step("R4");
    expect_gnt("R4", 2);

    // R5: level 2 pointer survives a level 6 burst
    clear_all();
    set_lvl(3, 2); set_lvl(4, 2);
    step("R5");
    expect_gnt("R5", 3);
    set_lvl(0, 6); set_lvl(7, 6);
    for (int k = 0; k < 3; k++) step("R5");
    set_lvl(0, 0); set_lvl(7, 0);
    step("R5");
    expect_gnt("R5", 4);

    // R6: hold keeps grant against higher level, stop and enable; R11 with hold
    clear_all();
    set_lvl(5, 1);
    step("R6");
    expect_gnt("R6", 5);
    hold[5] = 1'b1; set_lvl(2, 7);
    step("R6");
    expect_gnt("R6", 5);
    stop = 1'b1; en = 1'b0; set_lvl(5, 0);
    step("R6");
    expect_gnt("R6", 5);
    stop = 1'b0; en = 1'b1; hold = '0;
    step("R6");
    expect_gnt("R6", 2);

    // R7: hold from a non-granted master changes nothing
    clear_all();
    set_lvl(0, 4); set_lvl(1, 4);
    step("R7");
    hold = 8'hFE & ~gnt;
    step("R7");
    step("R7");
    hold = '0;

    // R8: stop empties the grant and is echoed
    stop = 1'b1;
    step("R8");
    expect_gnt("R8", -1);
    step("R8");
    stop = 1'b0;
    step("R8");

    // R9: enable low empties the grant, pointers frozen
    en = 1'b0;
    step("R9");
    expect_gnt("R9", -1);
    step("R9");
    en = 1'b1;
    step("R9");

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      for (int p = 0; p < 8; p++) set_lvl(p, ($urandom % 3 == 0) ? int'($urandom % 8) : 0);
      hold = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      stop = ($urandom % 16 == 0);
      en   = ($urandom % 16 != 0);
      step("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule